// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block holds the tag and status state of a cache whose geometry and associativity are chosen by parameters. It does not store data. Each request is accepted in one cycle. The block answers whether the request hit, and it reports which way was used and whether a valid line had to be displaced. Any miss allocates a line in the indexed set. The block tries the lowest-numbered invalid way first. When the set has no invalid way, a separate victim selector picks the way to replace, using the per-line frequency, insertion-age and recency metadata.

Reads and writes are classified differently. A read hits only on a valid line whose tag matches. A write hits on a tag match alone, even when the line is invalid. The two kinds of hit also update different metadata. A flush input clears the whole directory, and four counters report hits, misses, evictions and flushes.

The address is split into three fields. The byte offset is the low `BLOCK_W` bits. The set index is the next `SET_W` bits. The tag is the remaining upper bits. `CACHE_W` and `BLOCK_W` set the cache size and block size as powers of two. `WAYS` gives the number of ways per set: 1 means direct mapped, a power of two means n-way, and -1 means fully associative. The parameter `POLICY` chooses the victim policy: least recent access, oldest insertion, least used, or pseudo-random. Elaboration rejects a way count that is zero or is not a power of two.

Top module: `cache_tag_dir`

## Requirements
- R1: Requests whose addresses differ only in the low `BLOCK_W` offset bits refer to the same line. The set index is taken from the `SET_W` bits just above the offset.
- R2: A read hits only when some way of the indexed set is valid and holds the request tag. A read hit increments `hit_cnt_o` and refreshes the line's use count and last-access stamp.
- R3: A write hits on a tag match in the indexed set regardless of the valid bit. A write to tag 0 right after reset or flush is therefore a hit in way 0. A write hit increments `hit_cnt_o`, refreshes only the last-access stamp, and allocates nothing.
- R4: A miss increments `miss_cnt_o` and fills the lowest-index invalid way of the set. The response reports that way with `resp_evict_o` low.
- R5: A miss in a set with no invalid way fills the way named by the victim selector and increments `inval_cnt_o`. The response reports that way with `resp_evict_o` high. With the default least-recent-access policy, the victim is the way with the smallest last-access stamp, and the lowest index wins a tie.
- R6: A fill writes the tag, marks the line valid, clears its use count and last-access stamp, and records the current time as its insertion stamp. A freshly filled line that has not been accessed since is therefore the oldest line under the recency policy.
- R7: `flush_i` invalidates every line, clears all line metadata and increments `flush_cnt_o`. While `flush_i` is high, `req_ready_o` is low and a request presented in that cycle is not accepted.
- R8: A request is accepted on a rising edge where `req_valid_i` and `req_ready_o` are both high. Its response (`resp_valid_o`, `resp_hit_o`, `resp_way_o`, `resp_evict_o`) and the counter updates appear after that same edge. `resp_valid_o` is low in every other cycle.
- R9: After reset all counters read 0, `resp_valid_o` is low, `req_ready_o` is high, and every line is invalid with tag 0.
- R10: With `WAYS` = -1, all lines form a single set, so every tag competes for every way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted (low during flush) |
| req_addr_i | input | ADDR_W | Byte address of the request |
| req_write_i | input | 1 | 1 for write, 0 for read |
| flush_i | input | 1 | Invalidate the whole directory |
| resp_valid_o | output | 1 | Response for the request accepted at the last edge |
| resp_hit_o | output | 1 | Request hit |
| resp_way_o | output | WAY_W | Way that was hit or filled |
| resp_evict_o | output | 1 | Miss replaced a valid line |
| hit_cnt_o | output | CNT_W | Number of hits |
| miss_cnt_o | output | CNT_W | Number of misses |
| inval_cnt_o | output | CNT_W | Number of valid lines replaced |
| flush_cnt_o | output | CNT_W | Number of flushes |

## Verification
The first pattern is directed. Writes and reads to tag 0 right after reset separate write classification, which ignores the valid bit, from read classification, which requires it. A scripted sequence in one set fills all four ways, touches two of them, and then misses twice. Each of those misses must land on a never-touched way, which confirms both that the recency victim is chosen correctly and that a fill clears the access stamp. A random mix of reads and writes follows, over six tags in all four sets with random offsets and occasional flushes, some of them colliding with a request. It is compared request by request against a model for hit, way, eviction and all counters, which exposes wrong set selection, wrong free-way order and wrong flush priority. A second instance built fully associative confirms that tags which would fall into different sets still share one set.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  typedef enum logic [1:0] {
    VICT_LRU  = 2'd0,
    VICT_FIFO = 2'd1,
    VICT_LFU  = 2'd2,
    VICT_RAND = 2'd3
  } vict_pol_e;
endpackage

// File: rtl/cache_tag_lookup.sv
module cache_tag_lookup #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 10,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [TAG_W-1:0]           tag_i,
  input  logic                       write_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           hit_way_o,
  output logic                       free_o,
  output logic [WAY_W-1:0]           free_way_o
);
  // scan downwards so the lowest index wins
  always_comb begin
    hit_o      = 1'b0;
    hit_way_o  = '0;
    free_o     = 1'b0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (tags_i[w] == tag_i && (write_i || valid_i[w])) begin
        hit_o     = 1'b1;
        hit_way_o = WAY_W'(w);
      end
      if (!valid_i[w]) begin
        free_o     = 1'b1;
        free_way_o = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/cache_tag_victim.sv
module cache_tag_victim
  import cache_tag_pkg::*;
#(
  parameter int        WAYS    = 4,
  parameter int        WAY_W   = 2,
  parameter int        STAMP_W = 32,
  parameter int        USE_W   = 8,
  parameter vict_pol_e POLICY  = VICT_LRU
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [WAYS-1:0][USE_W-1:0]      use_i,
  input  logic [WAYS-1:0][STAMP_W-1:0]    ins_i,
  input  logic [WAYS-1:0][STAMP_W-1:0]    acc_i,
  output logic [WAY_W-1:0]                victim_o
);
  localparam int LFSR_W = 16;

  logic [LFSR_W-1:0]  lfsr_q;
  logic [WAY_W-1:0]   min_way;
  logic [STAMP_W-1:0] min_key;
  logic [STAMP_W-1:0] key;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= LFSR_W'(1);
    else         lfsr_q <= {lfsr_q[LFSR_W-2:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  // strict less-than keeps the lowest index on ties
  always_comb begin
    min_way = '0;
    min_key = '1;
    key     = '0;
    for (int w = 0; w < WAYS; w++) begin
      case (POLICY)
        VICT_LFU:  key = STAMP_W'(use_i[w]);
        VICT_FIFO: key = ins_i[w];
        default:   key = acc_i[w];
      endcase
      if (w == 0 || key < min_key) begin
        min_key = key;
        min_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (POLICY == VICT_RAND) victim_o = (WAYS > 1) ? lfsr_q[WAY_W-1:0] : '0;
    else                     victim_o = min_way;
  end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import cache_tag_pkg::*;
#(
  parameter int        ADDR_W  = 16,
  parameter int        CACHE_W = 8,
  parameter int        BLOCK_W = 4,
  parameter int        WAYS    = 4,
  parameter vict_pol_e POLICY  = VICT_LRU,
  parameter int        STAMP_W = 32,
  parameter int        USE_W   = 8,
  parameter int        CNT_W   = 16,
  localparam int LINES    = 2 ** (CACHE_W - BLOCK_W),
  localparam int WAYS_EFF = (WAYS == -1) ? LINES : WAYS,
  localparam int WAY_W    = (WAYS_EFF > 1) ? $clog2(WAYS_EFF) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic              flush_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [WAY_W-1:0]  resp_way_o,
  output logic              resp_evict_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o,
  output logic [CNT_W-1:0]  inval_cnt_o,
  output logic [CNT_W-1:0]  flush_cnt_o
);
  localparam int SETS   = (WAYS_EFF > 0) ? LINES / WAYS_EFF : 1;
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 0;
  localparam int SET_WI = (SET_W > 0) ? SET_W : 1;
  localparam int TAG_W  = ADDR_W - BLOCK_W - SET_W;
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;

  if (WAYS_EFF <= 0 || (WAYS_EFF & (WAYS_EFF - 1)) != 0 || WAYS_EFF > LINES) begin : g_bad_ways
    $error("cache_tag_dir: WAYS must be -1 or a power of two not above the line count");
  end

  // line state
  logic [TAG_W-1:0]   tag_q [LINES];
  logic               val_q [LINES];
  logic [USE_W-1:0]   use_q [LINES];
  logic [STAMP_W-1:0] ins_q [LINES];
  logic [STAMP_W-1:0] acc_q [LINES];

  logic [STAMP_W-1:0] now_q;
  logic [SET_WI-1:0]  set_idx;
  logic [TAG_W-1:0]   req_tag;

  logic [WAYS_EFF-1:0][TAG_W-1:0]   set_tag;
  logic [WAYS_EFF-1:0]              set_val;
  logic [WAYS_EFF-1:0][USE_W-1:0]   set_use;
  logic [WAYS_EFF-1:0][STAMP_W-1:0] set_ins;
  logic [WAYS_EFF-1:0][STAMP_W-1:0] set_acc;

  logic             hit, free_any, accept;
  logic [WAY_W-1:0] hit_way, free_way, victim_way, alloc_way;
  logic [LINE_W-1:0] hit_line, fill_line;

  logic             resp_valid_q, resp_hit_q, resp_evict_q;
  logic [WAY_W-1:0] resp_way_q;
  logic [CNT_W-1:0] hit_cnt_q, miss_cnt_q, inval_cnt_q, flush_cnt_q;

  if (SET_W > 0) begin : g_set
    assign set_idx = req_addr_i[BLOCK_W +: SET_WI];
  end else begin : g_one_set
    assign set_idx = '0;
  end
  assign req_tag = req_addr_i[ADDR_W-1 -: TAG_W];

  always_comb begin
    for (int w = 0; w < WAYS_EFF; w++) begin
      set_tag[w] = tag_q[int'(set_idx) * WAYS_EFF + w];
      set_val[w] = val_q[int'(set_idx) * WAYS_EFF + w];
      set_use[w] = use_q[int'(set_idx) * WAYS_EFF + w];
      set_ins[w] = ins_q[int'(set_idx) * WAYS_EFF + w];
      set_acc[w] = acc_q[int'(set_idx) * WAYS_EFF + w];
    end
  end

  cache_tag_lookup #(
    .WAYS (WAYS_EFF),
    .TAG_W(TAG_W),
    .WAY_W(WAY_W)
  ) u_lookup (
    .tags_i    (set_tag),
    .valid_i   (set_val),
    .tag_i     (req_tag),
    .write_i   (req_write_i),
    .hit_o     (hit),
    .hit_way_o (hit_way),
    .free_o    (free_any),
    .free_way_o(free_way)
  );

  cache_tag_victim #(
    .WAYS   (WAYS_EFF),
    .WAY_W  (WAY_W),
    .STAMP_W(STAMP_W),
    .USE_W  (USE_W),
    .POLICY (POLICY)
  ) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .use_i   (set_use),
    .ins_i   (set_ins),
    .acc_i   (set_acc),
    .victim_o(victim_way)
  );

  assign alloc_way   = free_any ? free_way : victim_way;
  assign hit_line    = LINE_W'(int'(set_idx) * WAYS_EFF + int'(hit_way));
  assign fill_line   = LINE_W'(int'(set_idx) * WAYS_EFF + int'(alloc_way));
  assign req_ready_o = !flush_i;
  assign accept      = req_valid_i && !flush_i;

  // time base starts at 1 so a cleared stamp is always oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) now_q <= STAMP_W'(1);
    else         now_q <= now_q + STAMP_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LINES; l++) begin
        tag_q[l] <= '0;
        val_q[l] <= 1'b0;
        use_q[l] <= '0;
        ins_q[l] <= '0;
        acc_q[l] <= '0;
      end
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_evict_q <= 1'b0;
      resp_way_q   <= '0;
      hit_cnt_q    <= '0;
      miss_cnt_q   <= '0;
      inval_cnt_q  <= '0;
      flush_cnt_q  <= '0;
    end else begin
      resp_valid_q <= accept;
      if (flush_i) begin
        for (int l = 0; l < LINES; l++) begin
          tag_q[l] <= '0;
          val_q[l] <= 1'b0;
          use_q[l] <= '0;
          ins_q[l] <= '0;
          acc_q[l] <= '0;
        end
        flush_cnt_q <= flush_cnt_q + CNT_W'(1);
      end else if (accept) begin
        resp_hit_q   <= hit;
        resp_way_q   <= hit ? hit_way : alloc_way;
        resp_evict_q <= !hit && !free_any;
        if (hit) begin
          acc_q[hit_line] <= now_q;
          if (!req_write_i && use_q[hit_line] != '1)
            use_q[hit_line] <= use_q[hit_line] + USE_W'(1);
          hit_cnt_q <= hit_cnt_q + CNT_W'(1);
        end else begin
          tag_q[fill_line] <= req_tag;
          val_q[fill_line] <= 1'b1;
          use_q[fill_line] <= '0;
          ins_q[fill_line] <= now_q;
          acc_q[fill_line] <= '0;
          miss_cnt_q <= miss_cnt_q + CNT_W'(1);
          if (!free_any) inval_cnt_q <= inval_cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign resp_valid_o = resp_valid_q;
  assign resp_hit_o   = resp_valid_q && resp_hit_q;
  assign resp_evict_o = resp_valid_q && resp_evict_q;
  assign resp_way_o   = resp_way_q;
  assign hit_cnt_o    = hit_cnt_q;
  assign miss_cnt_o   = miss_cnt_q;
  assign inval_cnt_o  = inval_cnt_q;
  assign flush_cnt_o  = flush_cnt_q;
endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             flush_i,
  input logic             resp_valid_o,
  input logic             resp_hit_o,
  input logic             resp_evict_o,
  input logic [CNT_W-1:0] hit_cnt_o,
  input logic [CNT_W-1:0] miss_cnt_o,
  input logic [CNT_W-1:0] inval_cnt_o,
  input logic [CNT_W-1:0] flush_cnt_o
);
  AST_FLUSH_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_ready_o); // R7
  AST_FLUSH_COUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> flush_cnt_o == $past(flush_cnt_o) + CNT_W'(1)); // R7
  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> resp_valid_o); // R8
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_ready_o) |=> !resp_valid_o); // R8
  AST_HIT_COUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_hit_o |-> hit_cnt_o == $past(hit_cnt_o) + CNT_W'(1)); // R2
  AST_MISS_COUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_hit_o) |-> miss_cnt_o == $past(miss_cnt_o) + CNT_W'(1)); // R4
  AST_EVICT_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_evict_o |-> (!resp_hit_o && inval_cnt_o == $past(inval_cnt_o) + CNT_W'(1))); // R5
  AST_INVAL_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_evict_o |-> $stable(inval_cnt_o)); // R5
endmodule

bind cache_tag_dir cache_tag_dir_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/cache_tag_dir_tb.sv
module cache_tag_dir_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int ADDR_W = 16;
  localparam int LINES  = 16;
  localparam int WAYS   = 4;
  localparam int TAG_W  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0, flush = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_ready, resp_valid, resp_hit, resp_evict;
  logic [1:0]        resp_way;
  logic [15:0]       hit_cnt, miss_cnt, inval_cnt, flush_cnt;

  cache_tag_dir u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write), .flush_i(flush),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_way_o(resp_way),
    .resp_evict_o(resp_evict), .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt),
    .inval_cnt_o(inval_cnt), .flush_cnt_o(flush_cnt)
  );

  // fully associative instance: 4 lines, one set
  logic              fa_valid = 1'b0;
  logic [ADDR_W-1:0] fa_addr = '0;
  logic              fa_ready, fa_rvalid, fa_hit, fa_evict;
  logic [1:0]        fa_way;
  logic [15:0]       fa_h, fa_m, fa_i, fa_f;

  cache_tag_dir #(.CACHE_W(6), .WAYS(-1)) u_fa (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(fa_valid), .req_ready_o(fa_ready),
    .req_addr_i(fa_addr), .req_write_i(1'b0), .flush_i(1'b0),
    .resp_valid_o(fa_rvalid), .resp_hit_o(fa_hit), .resp_way_o(fa_way),
    .resp_evict_o(fa_evict), .hit_cnt_o(fa_h), .miss_cnt_o(fa_m),
    .inval_cnt_o(fa_i), .flush_cnt_o(fa_f)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [TAG_W-1:0] m_tag [LINES];
  bit               m_val [LINES];
  int               m_acc [LINES];
  int m_seq = 1;
  int e_hit = 0, e_miss = 0, e_inv = 0, e_fl = 0;
  bit x_hit, x_evict;
  int x_way;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int l = 0; l < LINES; l++) begin
      m_tag[l] = '0; m_val[l] = 1'b0; m_acc[l] = 0;
    end
  endtask

  function automatic string outcome_tag(input bit wr);
    if (x_hit) return wr ? "R3" : "R2";
    if (x_evict) return "R5";
    return "R4";
  endfunction

  task automatic model_step(input logic [ADDR_W-1:0] a, input bit wr);
    int base = int'(a[5:4]) * WAYS;
    logic [TAG_W-1:0] t = a[15:6];
    int hw = -1, fw = -1, vw = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (hw < 0 && m_tag[base+w] == t && (wr || m_val[base+w])) hw = w;
      if (fw < 0 && !m_val[base+w]) fw = w;
      if (m_acc[base+w] < m_acc[base+vw]) vw = w;
    end
    if (hw >= 0) begin
      x_hit = 1'b1; x_evict = 1'b0; x_way = hw;
      m_acc[base+hw] = m_seq;
      e_hit++;
    end else begin
      x_hit = 1'b0;
      x_evict = (fw < 0);
      x_way = x_evict ? vw : fw;
      if (x_evict) e_inv++;
      m_tag[base+x_way] = t; m_val[base+x_way] = 1'b1; m_acc[base+x_way] = 0;
      e_miss++;
    end
    m_seq++;
  endtask

  task automatic do_req(input logic [ADDR_W-1:0] a, input bit wr);
    string r;
    model_step(a, wr);
    r = outcome_tag(wr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    check(resp_valid == 1'b1, "R8", int'(resp_valid), 1);
    check(resp_hit == x_hit, r, int'(resp_hit), int'(x_hit));
    check(int'(resp_way) == x_way, r, int'(resp_way), x_way);
    check(resp_evict == x_evict, "R5", int'(resp_evict), int'(x_evict));
    check(int'(hit_cnt) == e_hit, "R2", int'(hit_cnt), e_hit);
    check(int'(miss_cnt) == e_miss, "R4", int'(miss_cnt), e_miss);
    check(int'(inval_cnt) == e_inv, "R5", int'(inval_cnt), e_inv);
  endtask

  task automatic do_flush(input bit with_req, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    flush = 1'b1; req_valid = with_req; req_addr = a; req_write = 1'b0;
    #1;
    check(req_ready == 1'b0, "R7", int'(req_ready), 0);
    @(negedge clk);
    flush = 1'b0; req_valid = 1'b0;
    e_fl++;
    model_clear();
    check(int'(flush_cnt) == e_fl, "R7", int'(flush_cnt), e_fl);
    check(resp_valid == 1'b0, "R7", int'(resp_valid), 0);
    check(int'(miss_cnt) == e_miss && int'(hit_cnt) == e_hit, "R7", int'(miss_cnt), e_miss);
  endtask

  task automatic fa_req(input logic [ADDR_W-1:0] a, input bit eh, input int ew, input bit ee);
    @(negedge clk);
    fa_valid = 1'b1; fa_addr = a;
    @(negedge clk);
    fa_valid = 1'b0;
    check(fa_rvalid && fa_hit == eh, "R10", int'(fa_hit), int'(eh));
    check(int'(fa_way) == ew, "R10", int'(fa_way), ew);
    check(fa_evict == ee, "R10", int'(fa_evict), int'(ee));
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int set, input int off);
    return ADDR_W'((tag << 6) | (set << 4) | off);
  endfunction

  initial begin
    model_clear();
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check(hit_cnt == 0 && miss_cnt == 0 && inval_cnt == 0 && flush_cnt == 0, "R9", int'(miss_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(resp_valid == 1'b0, "R9", int'(resp_valid), 0);
    check(req_ready == 1'b1, "R9", int'(req_ready), 1);

    // write to tag 0 on invalid line: hit without valid
    do_req(mk(0, 1, 3), 1'b1);
    check(resp_hit == 1'b1 && resp_way == 2'd0, "R3", int'(resp_hit), 1);
    // read of same: invalid, so miss fills way 0
    do_req(mk(0, 1, 3), 1'b0);
    check(resp_hit == 1'b0 && resp_way == 2'd0, "R2", int'(resp_hit), 0);
    // offset-only change: same line
    do_req(mk(7, 3, 0), 1'b0);
    do_req(mk(7, 3, 15), 1'b0);
    check(resp_hit == 1'b1, "R1", int'(resp_hit), 1);
    // same tag, other set: separate line
    do_req(mk(7, 2, 0), 1'b0);
    check(resp_hit == 1'b0, "R1", int'(resp_hit), 0);

    // recency victim and fill clearing the access stamp
    do_flush(1'b0, '0);
    for (int t = 1; t <= 4; t++) do_req(mk(t, 2, 0), 1'b0);
    check(resp_way == 2'd3 && resp_evict == 1'b0, "R4", int'(resp_way), 3);
    do_req(mk(1, 2, 0), 1'b0);
    do_req(mk(3, 2, 0), 1'b0);
    do_req(mk(5, 2, 0), 1'b0);
    check(resp_way == 2'd1 && resp_evict == 1'b1, "R5", int'(resp_way), 1);
    do_req(mk(6, 2, 0), 1'b0);
    check(resp_way == 2'd1, "R6", int'(resp_way), 1);
    // write hit refreshes recency only; next victim is way 3
    do_req(mk(6, 2, 0), 1'b1);
    do_req(mk(8, 2, 0), 1'b0);
    check(resp_way == 2'd3, "R6", int'(resp_way), 3);

    // flush colliding with a request
    do_flush(1'b1, mk(1, 2, 0));
    do_req(mk(1, 2, 0), 1'b0);
    check(resp_hit == 1'b0, "R7", int'(resp_hit), 0);

    // random mix
    for (int i = 0; i < 500; i++) begin
      if ($urandom % 40 == 0) do_flush(1'($urandom % 2), mk(int'($urandom % 6), 0, 0));
      else do_req(mk(int'($urandom % 6), int'($urandom % 4), int'($urandom % 16)), ($urandom % 3) == 0);
    end

    // fully associative: bits that would be a set index are tag bits
    fa_req(16'h0010, 1'b0, 0, 1'b0);
    fa_req(16'h0020, 1'b0, 1, 1'b0);
    fa_req(16'h0030, 1'b0, 2, 1'b0);
    fa_req(16'h0040, 1'b0, 3, 1'b0);
    fa_req(16'h0010, 1'b1, 0, 1'b0);
    fa_req(16'h0050, 1'b0, 1, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule